// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Retransmit

This block is a single-clock FIFO controller with its own storage array. Words of a parameterised width (18 bits by default) are pushed on a write port and popped on a read port. A mode bit is captured during master reset and selects how the read port behaves. In standard timing a word reaches the data outputs only after an enabled read edge, and the two status outputs mean "full" and "empty". In fall-through timing the oldest stored word is already on the outputs without any read request, and the status outputs mean "space available" and "word valid".

Around the storage sit five active-low indicators: the two mode-dependent status flags, an almost-full flag, an almost-empty flag and a half-full flag. Both almost-flag thresholds come from an offset register block outside this one, as input ports. Two resets are provided. Master reset clears the pointers and the output register and samples the mode. Partial reset clears the same state but keeps the mode. A retransmit input moves the read side back to the first physical location so that data can be read again. It does not touch the write side. An output enable forces the data outputs to zero while leaving the internal output register unchanged.

Top module: `dmf_fifo`

## Requirements
- R1: While mrst_n is low at a clock edge, the read and write pointers, the stored level and the output register go to zero, and the mode is sampled from mode_sel (0 = standard, 1 = fall-through). After that edge the flags read: standard out_flag_n=0, in_flag_n=1; fall-through out_flag_n=1, in_flag_n=0.
- R2: While prst_n is low at a clock edge (with mrst_n high), the pointers, the level and the output register go to zero, and the previously latched mode is kept.
- R3: In standard mode, an enabled read of a non-empty FIFO loads the oldest word into the output register at that edge. Words come out in write order.
- R4: In fall-through mode, the first word written into an empty FIFO is on rd_data right after its write edge with no read request. Each accepted read edge replaces it with the next word.
- R5: in_flag_n in standard mode is 0 exactly when DEPTH words are held. In fall-through mode it is 0 exactly when fewer than DEPTH words are held.
- R6: out_flag_n in standard mode is 0 when no word is held. In fall-through mode it is 0 when a valid word is presented on the outputs.
- R7: A write while DEPTH words are held is dropped and moves no pointer. A read while empty is ignored, and in standard mode rd_data keeps its value.
- R8: A clock edge with rewind high sets the read pointer to the first location and keeps the write pointer. For the following cycle the FIFO reports empty (standard out_flag_n=0, fall-through out_flag_n=1) and refuses reads. After that the words stored since the last reset are read again from the first one, followed by any later writes.
- R9: paf_n is 0 exactly when the held count exceeds DEPTH minus full_gap.
- R10: pae_n is 0 exactly when the held count is less than empty_gap.
- R11: hf_n is 0 exactly when the held count exceeds DEPTH/2.
- R12: When out_en is 0, rd_data is all zeros. The output register keeps its content, which returns when out_en rises.

Note: in fall-through mode the word on the outputs counts toward the held count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| mode_sel | input | 1 | Timing mode sampled during master reset (1 = fall-through) |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read request |
| rewind | input | 1 | Retransmit request |
| out_en | input | 1 | Output enable; zeros on rd_data when low |
| full_gap | input | $clog2(DEPTH)+1 | Almost-full offset |
| empty_gap | input | $clog2(DEPTH)+1 | Almost-empty offset |
| rd_data | output | DW | Read data |
| in_flag_n | output | 1 | Standard: full (low); fall-through: space available (low) |
| out_flag_n | output | 1 | Standard: empty (low); fall-through: word valid (low) |
| paf_n | output | 1 | Almost-full, active low |
| pae_n | output | 1 | Almost-empty, active low |
| hf_n | output | 1 | Half-full, active low |

## Verification
The bench builds the block with DEPTH=16 and the default 18-bit width. At that depth the full boundary, the half-full boundary and overflow attempts are each a few writes away, in both timing modes. The offsets are set to full_gap=3 and empty_gap=2, so both almost-flag transitions fall inside one fill sequence. Retransmit is exercised in both modes after a partial reset, which also shows that the latched mode survives that reset.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FWFT = 1'b1
   } rd_mode_e;
endpackage

// File: rtl/dmf_store.sv
module dmf_store #(
   parameter int DW    = 18,
   parameter int DEPTH = 2048,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/dmf_ptrs.sv
module dmf_ptrs #(
   parameter int DEPTH = 2048,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          clk,
   input  logic          mrst_n,
   input  logic          prst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic          rewind,
   output logic          push,
   output logic          pop,
   output logic [AW-1:0] wptr,
   output logic [AW-1:0] rptr,
   output logic [AW-1:0] rptr_nxt,
   output logic [LW-1:0] level,
   output logic          rt_hold
);
   localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

   logic [AW-1:0] wptr_nxt;
   logic [LW-1:0] level_nxt;

   always_comb begin
      push      = wr_en && (level != FULL_LVL);
      pop       = rd_en && !rewind && !rt_hold && (level != '0);
      wptr_nxt  = wptr + AW'(push);
      rptr_nxt  = rewind ? '0 : rptr + AW'(pop);
      level_nxt = rewind ? LW'(wptr_nxt)
                         : level + LW'(push) - LW'(pop);
   end

   always_ff @(posedge clk) begin
      if (!mrst_n || !prst_n) begin
         wptr    <= '0;
         rptr    <= '0;
         level   <= '0;
         rt_hold <= 1'b0;
      end else begin
         wptr    <= wptr_nxt;
         rptr    <= rptr_nxt;
         level   <= level_nxt;
         rt_hold <= rewind;
      end
   end
endmodule

// File: rtl/dmf_flags.sv
module dmf_flags #(
   parameter int DEPTH = 2048,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          fwft,
   input  logic          rt_hold,
   input  logic [LW-1:0] level,
   input  logic [LW-1:0] full_gap,
   input  logic [LW-1:0] empty_gap,
   output logic          in_flag_n,
   output logic          out_flag_n,
   output logic          paf_n,
   output logic          pae_n,
   output logic          hf_n
);
   localparam logic [LW:0]   DEPTH_X = (LW+1)'(DEPTH);
   localparam logic [LW-1:0] HALF    = LW'(DEPTH / 2);

   logic          is_full;
   logic          has_word;
   logic [LW:0]   full_sum;

   always_comb begin
      is_full    = (level == LW'(DEPTH));
      has_word   = (level != '0) && !rt_hold;
      full_sum   = {1'b0, level} + {1'b0, full_gap};
      in_flag_n  = fwft ? is_full : !is_full;
      out_flag_n = fwft ? !has_word : has_word;
      paf_n      = !(full_sum > DEPTH_X);
      pae_n      = !(level < empty_gap);
      hf_n       = !(level > HALF);
   end
endmodule

// File: rtl/dmf_fifo.sv
module dmf_fifo
   import dmf_pkg::*;
#(
   parameter int DW    = 18,
   parameter int DEPTH = 2048,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          clk,
   input  logic          mrst_n,
   input  logic          prst_n,
   input  logic          mode_sel,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic          rewind,
   input  logic          out_en,
   input  logic [LW-1:0] full_gap,
   input  logic [LW-1:0] empty_gap,
   output logic [DW-1:0] rd_data,
   output logic          in_flag_n,
   output logic          out_flag_n,
   output logic          paf_n,
   output logic          pae_n,
   output logic          hf_n
);
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 4) begin : g_bad_depth
      $error("dmf_fifo: DEPTH must be a power of two and at least 4");
   end
   if (DW < 1) begin : g_bad_width
      $error("dmf_fifo: DW must be positive");
   end

   rd_mode_e      mode_q;
   logic          push, pop, rt_hold, fwft, bypass;
   logic [AW-1:0] wptr, rptr, rptr_nxt, raddr;
   logic [LW-1:0] level;
   logic [DW-1:0] mem_rd, data_q;

   always_ff @(posedge clk) begin
      if (!mrst_n) mode_q <= mode_sel ? MODE_FWFT : MODE_STD;
   end

   assign fwft   = (mode_q == MODE_FWFT);
   assign raddr  = fwft ? rptr_nxt : rptr;
   assign bypass = push && (wptr == rptr_nxt);

   dmf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
      .wr_en(wr_en), .rd_en(rd_en), .rewind(rewind),
      .push(push), .pop(pop), .wptr(wptr), .rptr(rptr),
      .rptr_nxt(rptr_nxt), .level(level), .rt_hold(rt_hold)
   );

   dmf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk(clk), .we(push), .waddr(wptr), .wdata(wr_data),
      .raddr(raddr), .rdata(mem_rd)
   );

   dmf_flags #(.DEPTH(DEPTH)) u_flags (
      .fwft(fwft), .rt_hold(rt_hold), .level(level),
      .full_gap(full_gap), .empty_gap(empty_gap),
      .in_flag_n(in_flag_n), .out_flag_n(out_flag_n),
      .paf_n(paf_n), .pae_n(pae_n), .hf_n(hf_n)
   );

   // Output register: prefetch in fall-through, load-on-read in standard.
   always_ff @(posedge clk) begin
      if (!mrst_n || !prst_n) begin
         data_q <= '0;
      end else if (fwft) begin
         if (!rewind) data_q <= bypass ? wr_data : mem_rd;
      end else if (pop) begin
         data_q <= mem_rd;
      end
   end

   for (genvar b = 0; b < DW; b++) begin : g_lane
      assign rd_data[b] = out_en & data_q[b];
   end
endmodule

// File: rtl/dmf_fifo_chk.sv
module dmf_fifo_chk
   import dmf_pkg::*;
#(
   parameter int DW    = 18,
   parameter int DEPTH = 2048,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input logic          clk,
   input logic          mrst_n,
   input logic          prst_n,
   input logic          wr_en,
   input logic          rd_en,
   input logic          rewind,
   input logic          out_en,
   input logic [DW-1:0] rd_data,
   input logic          in_flag_n,
   input logic          out_flag_n,
   input rd_mode_e      mode,
   input logic [LW-1:0] level,
   input logic [AW-1:0] wptr,
   input logic [AW-1:0] rptr,
   input logic          rt_hold
);
   logic was_mrst = 1'b0;
   always_ff @(posedge clk) begin
      was_mrst <= !mrst_n;
      if (was_mrst && out_en)
         a_r1_reset_clears : assert (rd_data == '0 && level == '0);
   end

   a_r12_oe_zero : assert property (@(posedge clk) disable iff (!mrst_n)
      !out_en |-> rd_data == '0);

   a_r7_no_overflow : assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
      (level == LW'(DEPTH) && wr_en && !rd_en && !rewind)
      |=> (level == LW'(DEPTH) && $stable(wptr)));

   a_r7_no_underflow : assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
      (level == '0 && !wr_en && !rewind) |=> (level == '0 && $stable(rptr)));

   a_r8_rewind_empty : assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
      rewind |=> (rt_hold && out_flag_n == (mode == MODE_FWFT)));

   a_r2_mode_kept : assert property (@(posedge clk) disable iff (!mrst_n)
      !prst_n |=> $stable(mode));

   a_r6_valid_nonempty : assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
      (mode == MODE_FWFT && !out_flag_n) |-> level != '0);

   a_r5_full_not_empty : assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
      (mode == MODE_STD && !in_flag_n) |-> out_flag_n);
endmodule

bind dmf_fifo dmf_fifo_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .wr_en(wr_en),
   .rd_en(rd_en), .rewind(rewind), .out_en(out_en), .rd_data(rd_data),
   .in_flag_n(in_flag_n), .out_flag_n(out_flag_n), .mode(mode_q),
   .level(level), .wptr(wptr), .rptr(rptr), .rt_hold(rt_hold)
);

// File: tb/dmf_fifo_tb.sv
module dmf_fifo_tb;
   localparam int DW = 18;
   localparam int DEPTH = 16;
   localparam int LW = $clog2(DEPTH) + 1;
   localparam int VW = 1 + 1 + DW + DW + 1;
   localparam int NV = 8;

   // {wr, rd, wdata, expected rd_data, expected out_flag_n}; standard mode
   localparam logic [VW-1:0] VEC [NV] = '{
      {1'b1, 1'b0, 18'h000A1, 18'h00000, 1'b1},
      {1'b1, 1'b0, 18'h000A2, 18'h00000, 1'b1},
      {1'b0, 1'b1, 18'h00000, 18'h000A1, 1'b1},
      {1'b1, 1'b1, 18'h000A3, 18'h000A2, 1'b1},
      {1'b0, 1'b1, 18'h00000, 18'h000A3, 1'b0},
      {1'b0, 1'b1, 18'h00000, 18'h000A3, 1'b0},
      {1'b1, 1'b0, 18'h00005, 18'h000A3, 1'b1},
      {1'b0, 1'b1, 18'h00000, 18'h00005, 1'b0}
   };

   logic clk = 1'b0;
   logic mrst_n = 1'b0, prst_n = 1'b1, mode_sel = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0, rewind = 1'b0, out_en = 1'b1;
   logic [DW-1:0] wr_data = '0;
   logic [LW-1:0] full_gap = LW'(3), empty_gap = LW'(2);
   logic [DW-1:0] rd_data;
   logic in_flag_n, out_flag_n, paf_n, pae_n, hf_n;
   int total = 0, bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dmf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_sel(mode_sel),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rewind(rewind),
      .out_en(out_en), .full_gap(full_gap), .empty_gap(empty_gap),
      .rd_data(rd_data), .in_flag_n(in_flag_n), .out_flag_n(out_flag_n),
      .paf_n(paf_n), .pae_n(pae_n), .hf_n(hf_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      wr_en = 1'b0; rd_en = 1'b0; rewind = 1'b0;
   endtask

   task automatic master_reset(input logic m);
      idle(); mode_sel = m; mrst_n = 1'b0;
      step(); step();
      mrst_n = 1'b1;
   endtask

   task automatic wr1(input logic [DW-1:0] d);
      wr_en = 1'b1; rd_en = 1'b0; wr_data = d; step(); idle();
   endtask

   task automatic rd1();
      rd_en = 1'b1; wr_en = 1'b0; step(); idle();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      master_reset(1'b0);
      // R1 reset state, standard mode
      chk("R1 data", rd_data, 0);
      chk("R1 out_flag std", out_flag_n, 0);
      chk("R1 in_flag std", in_flag_n, 1);
      chk("R10 pae at 0", pae_n, 0);
      chk("R9 paf at 0", paf_n, 1);
      chk("R11 hf at 0", hf_n, 1);

      // Vector walk: R3 order, R6 empty flag, R7 read while empty
      for (int i = 0; i < NV; i++) begin
         wr_en = VEC[i][VW-1]; rd_en = VEC[i][VW-2];
         wr_data = VEC[i][VW-3 -: DW];
         step(); idle();
         chk("R3 vec data", rd_data, VEC[i][DW:1]);
         chk("R6 vec out_flag", out_flag_n, VEC[i][0]);
      end

      // Fill: R9, R10, R11, R5 boundaries
      for (int i = 0; i < DEPTH; i++) begin
         wr1(DW'(32'h100 + i));
         if (i + 1 == 1)  chk("R10 pae level1", pae_n, 0);
         if (i + 1 == 2)  chk("R10 pae level2", pae_n, 1);
         if (i + 1 == 8)  chk("R11 hf level8", hf_n, 1);
         if (i + 1 == 9)  chk("R11 hf level9", hf_n, 0);
         if (i + 1 == 13) chk("R9 paf level13", paf_n, 1);
         if (i + 1 == 14) chk("R9 paf level14", paf_n, 0);
         if (i + 1 == 15) chk("R5 std not full", in_flag_n, 1);
      end
      chk("R5 std full", in_flag_n, 0);
      wr1(18'h3FFFF);
      chk("R7 full after dropped write", in_flag_n, 0);
      for (int i = 0; i < DEPTH; i++) begin
         rd1();
         chk("R7 R3 drain order", rd_data, 32'h100 + i);
      end
      chk("R6 std empty after drain", out_flag_n, 0);

      // R2 partial reset keeps standard mode
      wr1(18'h00777);
      prst_n = 1'b0; step(); prst_n = 1'b1;
      chk("R2 data cleared", rd_data, 0);
      chk("R2 std mode kept", out_flag_n, 0);

      // R8 retransmit, standard
      for (int i = 0; i < 3; i++) wr1(DW'(32'h200 + i));
      rd1(); rd1();
      chk("R8 before rewind", rd_data, 32'h201);
      rewind = 1'b1; rd_en = 1'b1; step(); rewind = 1'b0;
      chk("R8 std empty after rewind", out_flag_n, 0);
      step(); rd_en = 1'b0;
      chk("R8 read refused in hold", rd_data, 32'h201);
      chk("R8 std refilled", out_flag_n, 1);
      rd1();
      chk("R8 first word again", rd_data, 32'h200);
      wr1(18'h00203);
      for (int i = 1; i < 4; i++) begin
         rd1();
         chk("R8 replay then append", rd_data, 32'h200 + i);
      end
      chk("R8 empty after replay", out_flag_n, 0);

      // R12 output enable
      out_en = 1'b0; step();
      chk("R12 zero when disabled", rd_data, 0);
      out_en = 1'b1; step();
      chk("R12 held value returns", rd_data, 32'h203);

      // Fall-through mode
      master_reset(1'b1);
      chk("R1 fwft out_flag", out_flag_n, 1);
      chk("R1 fwft in_flag", in_flag_n, 0);
      chk("R1 fwft data", rd_data, 0);
      wr1(18'h00C00);
      chk("R4 first word falls through", rd_data, 32'hC00);
      chk("R6 fwft valid", out_flag_n, 0);
      wr1(18'h00C01);
      chk("R4 head kept", rd_data, 32'hC00);
      rd1();
      chk("R4 advance", rd_data, 32'hC01);
      rd1();
      chk("R6 fwft drained", out_flag_n, 1);
      rd1();
      chk("R7 fwft read empty", out_flag_n, 1);
      for (int i = 0; i < DEPTH; i++) begin
         wr1(DW'(32'hD00 + i));
         if (i + 1 == 15) chk("R5 fwft space", in_flag_n, 0);
      end
      chk("R5 fwft no space", in_flag_n, 1);
      wr1(18'h3FFFF);
      for (int i = 0; i < DEPTH; i++) begin
         chk("R4 R7 fwft order", rd_data, 32'hD00 + i);
         rd1();
      end
      chk("R6 fwft empty after drain", out_flag_n, 1);

      // R2 partial reset keeps fall-through, then R8 retransmit
      prst_n = 1'b0; step(); prst_n = 1'b1;
      chk("R2 fwft mode kept", out_flag_n, 1);
      wr1(18'h00E00); wr1(18'h00E01);
      rd1();
      chk("R8 fwft before rewind", rd_data, 32'hE01);
      rewind = 1'b1; step(); rewind = 1'b0;
      chk("R8 fwft not ready after rewind", out_flag_n, 1);
      step();
      chk("R8 fwft ready again", out_flag_n, 0);
      chk("R8 fwft first word again", rd_data, 32'hE00);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule